// File: doc/BRIEF.md
# Mode-Masked GPIO Port Register Block

This block is the register slice of a general-purpose I/O port with up to sixteen pins. It holds three 32-bit registers behind a small word-addressed bus: a mode register with a 2-bit field per pin, a pin-level data register and a pull-up enable register. Software configures each pin's mode, then writes the data register. Only the bits of pins whose mode is "output" take the written value. Every other data bit keeps its stored value.

Reads return the stored contents with one exception. Two designated pins, 14 and 15 by default, read as logic one while their mode field selects "input". This makes an idle open-drain bus on those pins appear pulled high to polling software. The override affects only the read path. The stored data bits are never altered by it. Pad drivers and alternate pin functions sit outside this block.

Top module: `gpio_port_regs`

## Requirements
- R1: The mode register sits at byte offset 0x40. It is a plain 32-bit read/write register and resets to zero. Pin n's mode field occupies bits 2n+1:2n.
- R2: The pull-up register sits at byte offset 0x48. It is a plain 32-bit read/write register with no side effects and resets to zero.
- R3: The data register sits at byte offset 0x44, one word above the mode register, and resets to zero. Directly after reset, a read of 0x44 returns 0x0000_C000.
- R4: The mode code 2'b01 marks a pin as an output. The codes 2'b00 (input), 2'b10 and 2'b11 do not.
- R5: A data write stores (old AND NOT m) OR (value AND m). Bit n of m is set only when pin n's mode field is 2'b01. Data bits 16 to 31 are never written.
- R6: When bits 29:28 of the mode register equal 2'b00, data bit 14 reads as 1. When bits 31:30 equal 2'b00, data bit 15 reads as 1. For any other code, these bits read their stored value.
- R7: The read override never changes the stored data. After a pin leaves input mode, it reads back its stored bit again.
- R8: A read of any byte address other than 0x40, 0x44 and 0x48 returns zero, and a write there changes no register.
- R9: A write takes effect at the rising clock edge where wr_en is high. The read data is a combinational function of addr and the register state.
- R10: A mode register write is used to mask a data write issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a single-cycle 32-bit write |
| addr | input | 8 | Byte address of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |

## Verification
Every write is due at the rising edge on which wr_en is sampled high. Every read is due in the same cycle that addr is presented, with no register in the read path. The bench drives each access just after a falling edge and compares rd_data one time unit later against a behavioural model holding the state from before the coming edge. It then applies the access to the model at the rising edge. A data write that follows a mode write is therefore checked against the mode value committed one edge earlier. Each read after a write observes the state from exactly one edge later.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      PM_INPUT  = 2'b00,
      PM_OUTPUT = 2'b01,
      PM_ALT_A  = 2'b10,
      PM_ALT_B  = 2'b11
   } pin_mode_e;

   typedef struct packed {
      logic mode_hit;
      logic data_hit;
      logic pull_hit;
   } reg_sel_t;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
   import gpio_port_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] MODE_OFS = 'h40,
   parameter logic [ADDR_W-1:0] DATA_OFS = 'h44,
   parameter logic [ADDR_W-1:0] PULL_OFS = 'h48
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   if ((MODE_OFS == DATA_OFS) || (MODE_OFS == PULL_OFS) || (DATA_OFS == PULL_OFS)) begin : g_ofs_clash
      $error("gpio_reg_decode: register offsets must be distinct");
   end

   always_comb begin
      sel          = '0;
      sel.mode_hit = (addr == MODE_OFS);
      sel.data_hit = (addr == DATA_OFS);
      sel.pull_hit = (addr == PULL_OFS);
   end

endmodule

// File: rtl/gpio_mode_mask.sv
module gpio_mode_mask
   import gpio_port_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_PINS = 16
) (
   input  logic [DATA_W-1:0]   mode_reg,
   output logic [NUM_PINS-1:0] out_mask
);

   if (NUM_PINS * MODE_W > DATA_W) begin : g_fit_bad
      $error("gpio_mode_mask: mode fields do not fit the register");
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pin_mode_e mode_p;
      assign mode_p      = pin_mode_e'(mode_reg[p*MODE_W +: MODE_W]);
      assign out_mask[p] = (mode_p == PM_OUTPUT);
   end

endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
   parameter int DATA_W   = 32,
   parameter int NUM_PINS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [DATA_W-1:0]   wval,
   input  logic [NUM_PINS-1:0] pin_mask,
   output logic [DATA_W-1:0]   data_q
);

   logic [DATA_W-1:0] full_mask;

   if (DATA_W > NUM_PINS) begin : g_pad
      assign full_mask = {{(DATA_W-NUM_PINS){1'b0}}, pin_mask};
   end else begin : g_nopad
      assign full_mask = pin_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (we) begin
         data_q <= (data_q & ~full_mask) | (wval & full_mask);
      end
   end

   // R5
   masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((data_q ^ $past(data_q)) & ~$past(full_mask)) == '0);

   // R5
   masked_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((data_q ^ $past(wval)) & $past(full_mask)) == '0);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(data_q));

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_port_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_PINS   = 16,
   parameter int HI_PIN_A   = 14,
   parameter int HI_PIN_B   = 15,
   parameter bit PULLHI_EN  = 1'b1
) (
   input  reg_sel_t          sel,
   input  logic [DATA_W-1:0] mode_q,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] pull_q,
   output logic [DATA_W-1:0] rd_data
);

   if ((HI_PIN_A >= NUM_PINS) || (HI_PIN_B >= NUM_PINS)) begin : g_pin_bad
      $error("gpio_read_mux: pull-high pins outside the port");
   end

   logic [DATA_W-1:0] force_hi;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (PULLHI_EN && (b < NUM_PINS) && ((b == HI_PIN_A) || (b == HI_PIN_B))) begin : g_hi
         assign force_hi[b] = (pin_mode_e'(mode_q[b*MODE_W +: MODE_W]) == PM_INPUT);
      end else begin : g_plain
         assign force_hi[b] = 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (1'b1)
         sel.mode_hit: rd_data = mode_q;
         sel.data_hit: rd_data = data_q | force_hi;
         sel.pull_hit: rd_data = pull_q;
         default:      rd_data = '0;
      endcase
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 8,
   parameter int                NUM_PINS  = 16,
   parameter logic [ADDR_W-1:0] MODE_OFS  = 'h40,
   parameter logic [ADDR_W-1:0] PULL_OFS  = 'h48,
   parameter int                HI_PIN_A  = 14,
   parameter int                HI_PIN_B  = 15,
   parameter bit                PULLHI_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam logic [ADDR_W-1:0] DATA_OFS = MODE_OFS + ADDR_W'(4);
   localparam int                HA_LO    = HI_PIN_A * MODE_W;
   localparam int                HB_LO    = HI_PIN_B * MODE_W;

   if (NUM_PINS < 1) begin : g_pins_bad
      $error("gpio_port_regs: NUM_PINS must be at least one");
   end

   reg_sel_t              sel;
   logic [DATA_W-1:0]     mode_q;
   logic [DATA_W-1:0]     pull_q;
   logic [DATA_W-1:0]     data_q;
   logic [NUM_PINS-1:0]   out_mask;

   gpio_reg_decode #(
      .ADDR_W   (ADDR_W),
      .MODE_OFS (MODE_OFS),
      .DATA_OFS (DATA_OFS),
      .PULL_OFS (PULL_OFS)
   ) u_decode (
      .addr (addr),
      .sel  (sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         pull_q <= '0;
      end else if (wr_en) begin
         if (sel.mode_hit) mode_q <= wr_data;
         if (sel.pull_hit) pull_q <= wr_data;
      end
   end

   gpio_mode_mask #(
      .DATA_W   (DATA_W),
      .NUM_PINS (NUM_PINS)
   ) u_mask (
      .mode_reg (mode_q),
      .out_mask (out_mask)
   );

   gpio_data_reg #(
      .DATA_W   (DATA_W),
      .NUM_PINS (NUM_PINS)
   ) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_en && sel.data_hit),
      .wval     (wr_data),
      .pin_mask (out_mask),
      .data_q   (data_q)
   );

   gpio_read_mux #(
      .DATA_W    (DATA_W),
      .NUM_PINS  (NUM_PINS),
      .HI_PIN_A  (HI_PIN_A),
      .HI_PIN_B  (HI_PIN_B),
      .PULLHI_EN (PULLHI_EN)
   ) u_rd (
      .sel     (sel),
      .mode_q  (mode_q),
      .data_q  (data_q),
      .pull_q  (pull_q),
      .rd_data (rd_data)
   );

   // R1
   mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == MODE_OFS) |=> (mode_q == $past(wr_data)));

   // R2
   pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == PULL_OFS) |=> (pull_q == $past(wr_data)));

   // R8
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != MODE_OFS && addr != DATA_OFS && addr != PULL_OFS) |-> (rd_data == '0));

   // R8
   unmapped_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != MODE_OFS && addr != DATA_OFS && addr != PULL_OFS)
      |=> ($stable(mode_q) && $stable(pull_q) && $stable(data_q)));

   if (PULLHI_EN) begin : g_pullhi_chk
      // R6
      pin_a_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (addr == DATA_OFS && mode_q[HA_LO +: MODE_W] == PM_INPUT) |-> rd_data[HI_PIN_A]);
      // R6
      pin_b_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (addr == DATA_OFS && mode_q[HB_LO +: MODE_W] == PM_INPUT) |-> rd_data[HI_PIN_B]);
   end

endmodule

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk;
   logic        rst_n;
   logic        wr_en;
   logic [7:0]  addr;
   logic [31:0] wr_data;
   logic [31:0] rd_data;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   // behavioural reference state
   logic [31:0] m_mode;
   logic [31:0] m_data;
   logic [31:0] m_pull;

   gpio_port_regs u_gpio_port_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] ref_read(input logic [7:0] a);
      logic [31:0] v;
      case (a)
         8'h40: v = m_mode;
         8'h44: begin
            v = m_data;
            if (m_mode[29:28] == 2'b00) v[14] = 1'b1;
            if (m_mode[31:30] == 2'b00) v[15] = 1'b1;
         end
         8'h48: v = m_pull;
         default: v = 32'h0;
      endcase
      return v;
   endfunction

   task automatic ref_write(input logic [7:0] a, input logic [31:0] d);
      case (a)
         8'h40: m_mode = d;
         8'h48: m_pull = d;
         8'h44: begin
            for (int n = 0; n < 16; n++) begin
               if (m_mode[2*n +: 2] == 2'b01) m_data[n] = d[n];
            end
         end
         default: ;
      endcase
   endtask

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, addr, got, exp);
      end
   endtask

   task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d, input string tag);
      @(negedge clk);
      wr_en   = we;
      addr    = a;
      wr_data = d;
      #1;
      check(tag, rd_data, ref_read(a));
      @(posedge clk);
      if (we) ref_write(a, d);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired R9");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      addr    = 8'h00;
      wr_data = '0;
      m_mode  = '0;
      m_data  = '0;
      m_pull  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R3: reset values, pins 14 and 15 pulled high
      step(0, 8'h40, 0, "R1");
      step(0, 8'h48, 0, "R2");
      step(0, 8'h44, 0, "R3");
      check("R3", ref_read(8'h44), 32'h0000_C000);

      // R1 R4: all pins output, write all ones to data
      step(1, 8'h40, 32'h5555_5555, "R1");
      step(1, 8'h44, 32'hFFFF_FFFF, "R4");
      step(0, 8'h44, 0, "R5");
      check("R5", ref_read(8'h44), 32'h0000_FFFF);

      // R5: even pins output, odd pins input, clear data
      step(1, 8'h40, 32'h1111_1111, "R1");
      step(1, 8'h44, 32'h0000_0000, "R5");
      step(0, 8'h44, 0, "R5");
      check("R5", ref_read(8'h44), 32'h0000_AAAA);

      // R4 R6: codes 10 and 11 are not writable and give no override
      step(1, 8'h40, 32'hAAAA_FFFF, "R4");
      step(1, 8'h44, 32'h0000_5555, "R4");
      step(0, 8'h44, 0, "R6");
      check("R6", ref_read(8'h44), 32'h0000_AAAA);

      // R7: stored zero hidden by override and visible again afterwards
      step(1, 8'h40, 32'h5555_5555, "R1");
      step(1, 8'h44, 32'h0000_0000, "R5");
      step(0, 8'h44, 0, "R7");
      step(1, 8'h40, 32'h0000_0000, "R1");
      step(0, 8'h44, 0, "R6");
      check("R6", ref_read(8'h44), 32'h0000_C000);
      step(1, 8'h40, 32'hA000_0000, "R1");
      step(0, 8'h44, 0, "R7");
      check("R7", ref_read(8'h44), 32'h0000_0000);

      // R10: mode write followed at once by data write
      step(1, 8'h40, 32'h0000_0005, "R10");
      step(1, 8'h44, 32'hFFFF_FFFF, "R10");
      step(0, 8'h44, 0, "R10");
      check("R10", ref_read(8'h44), 32'h0000_C003);

      // R2: pull-up plain read/write
      step(1, 8'h48, 32'h1234_5678, "R2");
      step(0, 8'h48, 0, "R2");

      // R8: unmapped and misaligned offsets
      step(1, 8'h4C, 32'hFFFF_FFFF, "R8");
      step(1, 8'h41, 32'hFFFF_FFFF, "R8");
      step(1, 8'h00, 32'hFFFF_FFFF, "R8");
      step(0, 8'h4C, 0, "R8");
      step(0, 8'h40, 0, "R8");
      step(0, 8'h44, 0, "R8");
      step(0, 8'h48, 0, "R8");

      // R5 R6 R9: random traffic compared every clock
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] a;
         int unsigned pick;
         pick = $urandom_range(0, 4);
         case (pick)
            0: a = 8'h40;
            1, 2: a = 8'h44;
            3: a = 8'h48;
            default: a = 8'($urandom);
         endcase
         step(bit'($urandom_range(0, 1)), a, $urandom, "R9");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule